// File: doc/BRIEF.md
# SPI Chip-Select and Ready Handshake Sequencer

This block sits between a serial shift engine and the pins of an SPI controller. It brackets every word with programmable timing. A word request from the shift engine asserts chip-select. The block then holds off the first shift for a setup count of module clocks. It can also wait for the slave to pull its active-low ready line. Once these conditions are met, it grants a one-cycle go pulse. When the engine reports the last bit, the block can wait for ready to be released. It then keeps chip-select asserted for a hold count, releases it, and returns a one-cycle finished pulse.

The handshake has two failure paths. If ready never arrives, the word is abandoned and a timeout pulse is raised. If ready is never released, a desynchronisation pulse is raised and the word still completes. Chip-select can be left unused, for a ready-only link with no select line. It can also be kept asserted across words.

The four delays arrive packed in one configuration word, each field `DLY_W` bits wide. The bit shifting, the register file and interrupt routing live elsewhere.

Top module: `spi_csrdy_timer`

## Requirements
- R1: While reset is held and directly after it, `cs_n` is high and `shift_go`, `word_fin`, `err_tmo` and `err_desync` are low.
- R2: Call the rising edge that samples `word_req` in idle edge 0. `cs_n` goes low after edge 0 when `cs_used` is 1. Without the ready wait, `shift_go` is high for exactly one cycle after edge S+1, where S is the setup delay.
- R3: Without the ready wait, call the edge that samples `word_done` edge 0. `word_fin` pulses, and chip-select releases, after edge H+1, where H is the hold delay. Chip-select stays asserted in the cycle before.
- R4: When `timer_off` is 1, the setup and hold delays are used as zero. Both ready timeouts keep their programmed values.
- R5: When `wait_en` is 1, `rdy_n` is first sampled at edge S+2. `shift_go` pulses after the first edge that samples `rdy_n` low.
- R6: When `wait_en` is 1 and `rdy_n` is sampled high on every edge through edge S+2+A, `err_tmo` pulses after that edge. A is the start timeout. Chip-select releases in the same cycle, and neither `shift_go` nor `word_fin` follows for that word.
- R7: When `wait_en` is 1, `rdy_n` is sampled from the edge after the `word_done` edge onward. The first high sample starts the hold delay at that edge, so `word_fin` follows H+1 edges later.
- R8: When `wait_en` is 1 and `rdy_n` stays low through edge B+1 after the `word_done` edge, `err_desync` pulses after that edge. B is the end timeout. The hold delay then runs, and `word_fin` follows H+1 edges later.
- R9: When `cs_used` is 0, `cs_n` stays high for the whole word. Setup, hold and the ready handshake behave as with a select line.
- R10: When `cs_keep` is 1 at the end of a word, chip-select stays asserted after `word_fin`. If `cs_keep` drops while idle with no request pending, `cs_n` goes high after the next edge.
- R11: `dly_cfg` packs four fields of `DLY_W` bits: setup delay at the top field (bits 31:24 by default), hold delay next (23:16), end timeout next (15:8) and start timeout in the lowest field (7:0).
- R12: `word_done` has no effect unless a word is shifting, and `word_req` has no effect while a word is in progress.
- R13: `shift_go`, `word_fin`, `err_tmo` and `err_desync` are single-cycle pulses, and no two of them are high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dly_cfg | input | 4*DLY_W | Packed setup, hold, end-timeout and start-timeout counts |
| timer_off | input | 1 | Use zero for the setup and hold delays |
| wait_en | input | 1 | Enable the ready handshake |
| cs_used | input | 1 | Drive the chip-select line for this slave |
| cs_keep | input | 1 | Keep chip-select asserted after the word |
| word_req | input | 1 | Start-of-word request from the shift engine |
| word_done | input | 1 | Last-bit indication from the shift engine |
| rdy_n | input | 1 | Active-low ready from the slave, synchronous to clk |
| cs_n | output | 1 | Active-low chip-select |
| shift_go | output | 1 | Permission pulse to start shifting |
| word_fin | output | 1 | Word-finished pulse |
| err_tmo | output | 1 | Ready timeout error pulse |
| err_desync | output | 1 | Ready-release desynchronisation error pulse |

## Verification
The embedded assertions check, on every cycle, the pulse properties and the origin of each output. Pulses are single-cycle and mutually exclusive. A go pulse during the handshake needs a low ready sample. Timeouts come only from the ready-wait state and always release chip-select. A finish comes only from the hold phase. The counters never wrap, and stray end-of-word strobes leave the idle state alone. The exact latencies need the bench's scenarios, which sweep the delay fields, timer disable, both ready failure paths, the select-less mode and select keeping. Those latencies are S+1 to go, H+1 to release, and the two timeout windows.

// File: rtl/spi_csrdy_pkg.sv
package spi_csrdy_pkg;

    typedef enum logic [2:0] {
        PH_IDLE    = 3'd0,
        PH_SETUP   = 3'd1,
        PH_WAITRDY = 3'd2,
        PH_SHIFT   = 3'd3,
        PH_WAITREL = 3'd4,
        PH_HOLD    = 3'd5
    } phase_e;

    // Encoding equals the field index inside the packed delay word.
    typedef enum logic [1:0] {
        SEL_START = 2'd0,
        SEL_END   = 2'd1,
        SEL_HOLD  = 2'd2,
        SEL_SETUP = 2'd3
    } dsel_e;

    typedef struct packed {
        phase_e ph;
        logic   cs;
        logic   go;
        logic   fin;
        logic   tmo;
        logic   des;
    } seq_t;

endpackage

// File: rtl/spi_csrdy_dlysel.sv
module spi_csrdy_dlysel
    import spi_csrdy_pkg::*;
#(
    parameter int DLY_W = 8
) (
    input  logic [4*DLY_W-1:0] dly_cfg,
    input  logic               timer_off,
    input  dsel_e              sel,
    output logic [DLY_W-1:0]   val
);
    localparam int NFLD = 4;

    logic [DLY_W-1:0] fld [NFLD];

    generate
        for (genvar g = 0; g < NFLD; g++) begin : g_fld
            assign fld[g] = dly_cfg[g*DLY_W +: DLY_W];
        end
    endgenerate

    always_comb begin
        val = fld[int'(sel)];
        // The disable bit removes the setup and hold delays, not the timeouts.
        if (timer_off && (sel == SEL_SETUP || sel == SEL_HOLD)) begin
            val = '0;
        end
    end

endmodule

// File: rtl/spi_csrdy_cnt.sv
module spi_csrdy_cnt #(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             dec,
    input  logic [DLY_W-1:0] load_val,
    output logic [DLY_W-1:0] cnt,
    output logic             zero
);
    logic [DLY_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (dec) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt  = cnt_q;
    assign zero = (cnt_q == '0);

    // R2: the sequencer only counts down from a non-zero value.
    a_r2_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load) |-> (cnt_q != '0));

endmodule

// File: rtl/spi_csrdy_timer.sv
module spi_csrdy_timer
    import spi_csrdy_pkg::*;
#(
    parameter int DLY_W = 8,
    localparam int CFG_W = 4 * DLY_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] dly_cfg,
    input  logic             timer_off,
    input  logic             wait_en,
    input  logic             cs_used,
    input  logic             cs_keep,
    input  logic             word_req,
    input  logic             word_done,
    input  logic             rdy_n,
    output logic             cs_n,
    output logic             shift_go,
    output logic             word_fin,
    output logic             err_tmo,
    output logic             err_desync
);
    seq_t             seq_d, seq_q;
    logic             cnt_load, cnt_dec, cnt_zero;
    dsel_e            cnt_sel;
    logic [DLY_W-1:0] cnt_val, cnt_cur;

    spi_csrdy_dlysel #(.DLY_W(DLY_W)) u_sel (
        .dly_cfg   (dly_cfg),
        .timer_off (timer_off),
        .sel       (cnt_sel),
        .val       (cnt_val)
    );

    spi_csrdy_cnt #(.DLY_W(DLY_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .dec      (cnt_dec),
        .load_val (cnt_val),
        .cnt      (cnt_cur),
        .zero     (cnt_zero)
    );

    always_comb begin
        seq_d     = seq_q;
        seq_d.go  = 1'b0;
        seq_d.fin = 1'b0;
        seq_d.tmo = 1'b0;
        seq_d.des = 1'b0;
        cnt_load  = 1'b0;
        cnt_dec   = 1'b0;
        cnt_sel   = SEL_SETUP;
        unique case (seq_q.ph)
            PH_IDLE: begin
                if (word_req) begin
                    seq_d.ph = PH_SETUP;
                    seq_d.cs = cs_used;
                    cnt_load = 1'b1;
                    cnt_sel  = SEL_SETUP;
                end else if (seq_q.cs && !cs_keep) begin
                    seq_d.cs = 1'b0;
                end
            end
            PH_SETUP: begin
                if (!cnt_zero) begin
                    cnt_dec = 1'b1;
                end else if (wait_en) begin
                    seq_d.ph = PH_WAITRDY;
                    cnt_load = 1'b1;
                    cnt_sel  = SEL_START;
                end else begin
                    seq_d.ph = PH_SHIFT;
                    seq_d.go = 1'b1;
                end
            end
            PH_WAITRDY: begin
                if (!rdy_n) begin
                    seq_d.ph = PH_SHIFT;
                    seq_d.go = 1'b1;
                end else if (cnt_zero) begin
                    seq_d.ph  = PH_IDLE;
                    seq_d.cs  = 1'b0;
                    seq_d.tmo = 1'b1;
                end else begin
                    cnt_dec = 1'b1;
                end
            end
            PH_SHIFT: begin
                if (word_done) begin
                    cnt_load = 1'b1;
                    if (wait_en) begin
                        seq_d.ph = PH_WAITREL;
                        cnt_sel  = SEL_END;
                    end else begin
                        seq_d.ph = PH_HOLD;
                        cnt_sel  = SEL_HOLD;
                    end
                end
            end
            PH_WAITREL: begin
                if (rdy_n || cnt_zero) begin
                    seq_d.ph  = PH_HOLD;
                    seq_d.des = !rdy_n;
                    cnt_load  = 1'b1;
                    cnt_sel   = SEL_HOLD;
                end else begin
                    cnt_dec = 1'b1;
                end
            end
            PH_HOLD: begin
                if (cnt_zero) begin
                    seq_d.ph  = PH_IDLE;
                    seq_d.fin = 1'b1;
                    seq_d.cs  = seq_q.cs && cs_keep;
                end else begin
                    cnt_dec = 1'b1;
                end
            end
            default: begin
                seq_d.ph = PH_IDLE;
                seq_d.cs = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{ph: PH_IDLE, cs: 1'b0, go: 1'b0, fin: 1'b0,
                       tmo: 1'b0, des: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign cs_n       = !seq_q.cs;
    assign shift_go   = seq_q.go;
    assign word_fin   = seq_q.fin;
    assign err_tmo    = seq_q.tmo;
    assign err_desync = seq_q.des;

    a_r13_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({shift_go, word_fin, err_tmo, err_desync}));

    a_r13_go_single: assert property (@(posedge clk) disable iff (!rst_n)
        shift_go |=> !shift_go);

    a_r5_go_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_go && $past(wait_en) && $past(seq_q.ph == PH_WAITRDY)) |-> $past(!rdy_n));

    a_r6_tmo_releases: assert property (@(posedge clk) disable iff (!rst_n)
        err_tmo |-> (cs_n && $past(seq_q.ph == PH_WAITRDY)));

    a_r8_desync_origin: assert property (@(posedge clk) disable iff (!rst_n)
        err_desync |-> ($past(seq_q.ph == PH_WAITREL) && seq_q.ph == PH_HOLD));

    a_r3_fin_origin: assert property (@(posedge clk) disable iff (!rst_n)
        word_fin |-> $past(seq_q.ph == PH_HOLD));

    a_r12_done_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.ph == PH_IDLE && word_done && !word_req) |=> seq_q.ph == PH_IDLE);

    a_r2_setup_first: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.ph == PH_SHIFT && $past(seq_q.ph) != PH_SHIFT) |-> shift_go);

endmodule

// File: tb/tb_spi_csrdy_timer.sv
module tb_spi_csrdy_timer;

    localparam int DLY_W = 8;
    localparam int NV    = 9;
    localparam int NF    = 9;

    // Columns: setup, hold, end tmo, start tmo, timer_off, wait_en,
    //          cs_used, cs_keep, ready mode (0 normal, 1 never ready, 2 never released)
    localparam int V [NV][NF] = '{
        '{3, 2, 4, 5, 0, 0, 1, 0, 0},
        '{0, 0, 0, 0, 0, 0, 1, 0, 0},
        '{7, 9, 1, 1, 1, 0, 1, 0, 0},
        '{2, 1, 3, 4, 0, 1, 1, 0, 0},
        '{1, 2, 2, 6, 0, 1, 1, 0, 1},
        '{0, 2, 5, 3, 0, 1, 1, 0, 2},
        '{1, 1, 2, 2, 0, 1, 0, 0, 0},
        '{9, 9, 2, 3, 1, 1, 1, 0, 2},
        '{2, 3, 1, 1, 0, 0, 1, 1, 0}
    };

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [4*DLY_W-1:0] dly_cfg = '0;
    logic               timer_off = 1'b0, wait_en = 1'b0, cs_used = 1'b1, cs_keep = 1'b0;
    logic               word_req = 1'b0, word_done = 1'b0, rdy_n = 1'b1;
    logic               cs_n, shift_go, word_fin, err_tmo, err_desync;

    int n_checks = 0;
    int n_errors = 0;

    always #10 clk = ~clk;

    spi_csrdy_timer #(.DLY_W(DLY_W)) dut (
        .clk (clk), .rst_n (rst_n), .dly_cfg (dly_cfg),
        .timer_off (timer_off), .wait_en (wait_en), .cs_used (cs_used),
        .cs_keep (cs_keep), .word_req (word_req), .word_done (word_done),
        .rdy_n (rdy_n), .cs_n (cs_n), .shift_go (shift_go),
        .word_fin (word_fin), .err_tmo (err_tmo), .err_desync (err_desync)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic run_vec(input int i);
        int d, h, eb, sa, toff, wt, csu, kp, md;
        int n, go_n, tmo_n, m, fin_m, des_m, cs_fin, cs_prev;
        int e_go, e_tmo, e_fin, e_des;
        d = V[i][0]; h = V[i][1]; eb = V[i][2]; sa = V[i][3];
        toff = V[i][4]; wt = V[i][5]; csu = V[i][6]; kp = V[i][7]; md = V[i][8];
        // R11: field placement in the delay word
        dly_cfg   = {8'(d), 8'(h), 8'(eb), 8'(sa)};
        timer_off = toff[0]; wait_en = wt[0]; cs_used = csu[0]; cs_keep = kp[0];
        rdy_n     = (wt != 0 && md != 1) ? 1'b0 : 1'b1;
        word_req  = 1'b1;
        @(negedge clk);
        word_req = 1'b0;
        n = 1; go_n = -1; tmo_n = -1;
        chk($sformatf("R2/R9 v%0d cs_n after request", i), int'(cs_n), csu != 0 ? 0 : 1);
        while (n < 600) begin
            if (shift_go) begin go_n = n; break; end
            if (err_tmo) begin tmo_n = n; break; end
            @(negedge clk); n++;
        end
        if (toff != 0) begin d = 0; h = 0; end   // R4
        e_go  = (wt != 0) ? d + 3 : d + 2;
        e_tmo = d + sa + 3;
        if (wt != 0 && md == 1) begin
            chk($sformatf("R6 v%0d timeout latency", i), tmo_n, e_tmo);
            chk($sformatf("R6 v%0d cs released on timeout", i), int'(cs_n), 1);
            chk($sformatf("R6 v%0d no go on timeout", i), go_n, -1);
            repeat (4) begin
                @(negedge clk);
                chk($sformatf("R6 v%0d no finish after timeout", i), int'(word_fin | shift_go), 0);
            end
            rdy_n = 1'b1;
            return;
        end
        chk($sformatf("R2/R5 v%0d go latency", i), go_n, e_go);
        chk($sformatf("R9 v%0d cs_n during go", i), int'(cs_n), csu != 0 ? 0 : 1);
        @(negedge clk);
        chk($sformatf("R13 v%0d go single cycle", i), int'(shift_go), 0);
        repeat (2) @(negedge clk);
        word_done = 1'b1;
        if (wt != 0 && md == 0) rdy_n = 1'b1;
        @(negedge clk);
        word_done = 1'b0;
        m = 1; fin_m = -1; des_m = -1; cs_fin = -1; cs_prev = -1;
        while (m < 600) begin
            if (err_desync && des_m < 0) des_m = m;
            if (word_fin) begin fin_m = m; cs_fin = int'(cs_n); break; end
            cs_prev = int'(cs_n);
            @(negedge clk); m++;
        end
        if (wt == 0)      begin e_fin = h + 2;      e_des = -1;     end
        else if (md == 0) begin e_fin = h + 3;      e_des = -1;     end
        else              begin e_fin = eb + h + 3; e_des = eb + 2; end
        chk($sformatf("R3/R7 v%0d finish latency", i), fin_m, e_fin);
        chk($sformatf("R8 v%0d desync latency", i), des_m, e_des);
        chk($sformatf("R3 v%0d cs held before finish", i), cs_prev, csu != 0 ? 0 : 1);
        chk($sformatf("R3/R10 v%0d cs at finish", i), cs_fin, (csu != 0 && kp != 0) ? 0 : 1);
        rdy_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        int gos, fins;
        repeat (3) @(negedge clk);
        chk("R1 cs_n in reset", int'(cs_n), 1);
        chk("R1 pulses in reset", int'({shift_go, word_fin, err_tmo, err_desync}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 cs_n after reset", int'(cs_n), 1);
        chk("R1 pulses after reset", int'({shift_go, word_fin, err_tmo, err_desync}), 0);

        for (int i = 0; i < NV; i++) run_vec(i);

        // R10: the last table vector left chip-select kept asserted
        repeat (2) @(negedge clk);
        chk("R10 cs kept while idle", int'(cs_n), 0);
        cs_keep = 1'b0;
        @(negedge clk);
        chk("R10 cs released when keep drops", int'(cs_n), 1);

        // R12: stray word_done in idle
        word_done = 1'b1;
        @(negedge clk);
        word_done = 1'b0;
        fins = 0;
        repeat (6) begin
            @(negedge clk);
            fins += int'(word_fin | shift_go);
        end
        chk("R12 idle word_done ignored", fins, 0);
        chk("R12 cs after idle word_done", int'(cs_n), 1);

        // R12: second request during setup is ignored
        dly_cfg = {8'd4, 8'd0, 8'd0, 8'd0};
        timer_off = 1'b0; wait_en = 1'b0; cs_used = 1'b1;
        word_req = 1'b1;
        @(negedge clk);
        word_req = 1'b0;
        @(negedge clk);
        word_req = 1'b1;
        @(negedge clk);
        word_req = 1'b0;
        gos = 0;
        repeat (12) begin
            @(negedge clk);
            gos += int'(shift_go);
        end
        chk("R12 one go for overlapping requests", gos, 1);
        word_done = 1'b1;
        @(negedge clk);
        word_done = 1'b0;
        fins = 0;
        repeat (12) begin
            @(negedge clk);
            fins += int'(word_fin);
            gos  += int'(shift_go);
        end
        chk("R12 single finish", fins, 1);
        chk("R12 no extra go", gos, 1);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule